// File: doc/BRIEF.md
# Range Invalidate Sequencer

This block takes a request to invalidate an address range in a data cache and turns it into a series of area-invalidate commands for a cache-side engine. Each command covers one power-of-two block given by a base address and an address mask. The block size is chosen again for every command. It is the largest block that is naturally aligned at the current address and no larger than the bytes still left. The commands therefore tile the range exactly, without reaching beyond it.

Before the sequence starts, the range is fixed to line granularity. With write-back mode off, the start is rounded down and the end is rounded up to line boundaries. With write-back mode on, an unaligned start or end would discard dirty bytes that lie outside the range. Such a request is therefore not decomposed here. It is handed off unchanged through a one-cycle request to a flush-and-invalidate path. The sequencer waits for the engine to be idle before it issues its first command. After each command it waits for the engine to finish before it moves on. A done pulse marks the end of the range.

Top module: `range_inv_seq`

## Requirements
- R1: After reset, req_ready is 1 and cmd_valid, done and flush_req are 0.
- R2: With wb_mode at 0, the range is widened to whole lines of LINE_BYTES (16 by default) before decomposition. The start is rounded down and the end is rounded up, so an unaligned start of 0x5 with an end of 0x5 becomes one command over 0x0..0xF.
- R3: With wb_mode at 1, a request whose start or end has a nonzero bit below the line size produces exactly one one-cycle flush_req pulse. During that pulse, flush_start and flush_end carry the unmodified start and end. No command and no done pulse are produced for that request.
- R4: With wb_mode at 1, a request whose start and end are both line-aligned is decomposed in the same way as with wb_mode at 0.
- R5: No command is issued while eng_busy is high before the first command of a request. The first command follows the cycle in which eng_busy is seen low.
- R6: The block size for each command is chosen as follows. The candidate is the lowest set bit of the current address, or the whole remaining length when the address is zero. The block size is this candidate if the remaining length is strictly larger than it. Otherwise it is the highest power of two that does not exceed the remaining length.
- R7: cmd_mask equals the bitwise inverse of (block size - 1). cmd_word equals the current address with bit 0 (the invalidate bit) set and bit 1 (the write-back bit) clear.
- R8: When eng_busy is seen low after a command, the address advances by the block size and the remaining length shrinks by the same amount. The next command follows one cycle later. The commands are contiguous, and the last one ends exactly at the rounded end.
- R9: One cycle after the final command completes, done pulses for one cycle. A range that is empty after rounding (rounded end not above rounded start) gives a done pulse with no command.
- R10: Every command block is naturally aligned: the address bits covered by the inverse of cmd_mask are zero.
- R11: Only one command is outstanding at a time, and cmd_valid is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Range request, taken when req_ready is high |
| req_start | input | AW | First byte address of the range |
| req_end | input | AW | Address one past the last byte of the range |
| wb_mode | input | 1 | Write-back mode; selects hand-off for unaligned ranges |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| eng_busy | input | 1 | Area-invalidate engine busy; high from the cycle after a command until it finishes |
| cmd_valid | output | 1 | One-cycle command strobe to the engine |
| cmd_word | output | AW | Block base address with the invalidate bit set |
| cmd_mask | output | AW | Block address mask, inverse of (block size - 1) |
| flush_req | output | 1 | One-cycle hand-off to the flush-and-invalidate path |
| flush_start | output | AW | Original start, valid with flush_req |
| flush_end | output | AW | Original end, valid with flush_req |
| done | output | 1 | One-cycle pulse when a decomposed range is finished |

## Verification
Directed ranges separate the branches of the size rule. A range starting at address zero exercises the whole-length candidate. An aligned page-sized range yields a single block whose size equals the alignment. A small range at a highly aligned address forces the highest-bit search. Unaligned ranges are run once with write-back mode off and once with it on, which distinguishes rounding from hand-off. Empty ranges and a pre-request busy window show the zero-command completion and the initial wait. Random starts and lengths over many orders of magnitude produce long mixed chains of growing and shrinking blocks, and the exact command list is compared against a bench model.

// File: rtl/rinv_pkg.sv
package rinv_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_PRE   = 3'd1,
        S_ISSUE = 3'd2,
        S_WAIT  = 3'd3,
        S_FIN   = 3'd4,
        S_HAND  = 3'd5
    } seq_state_e;

endpackage

// File: rtl/rinv_range_prep.sv
module rinv_range_prep #(
    parameter int AW         = 32,
    parameter int LINE_SHIFT = 4
) (
    input  logic [AW-1:0] raw_start,
    input  logic [AW-1:0] raw_end,
    input  logic          wb_mode,
    output logic          redirect,
    output logic          empty,
    output logic [AW-1:0] start_r,
    output logic [AW-1:0] end_r,
    output logic [AW-1:0] len
);
    localparam logic [AW-1:0] LINE_LOW = AW'((64'd1 << LINE_SHIFT) - 64'd1);

    logic start_off;
    logic end_off;
    logic [AW-1:0] end_up;

    always_comb begin
        start_off = |(raw_start & LINE_LOW);
        end_off   = |(raw_end & LINE_LOW);
        redirect  = wb_mode && (start_off || end_off);
        end_up    = raw_end + LINE_LOW;
        start_r   = raw_start & ~LINE_LOW;
        end_r     = end_up & ~LINE_LOW;
        empty     = (end_r <= start_r);
        len       = end_r - start_r;
    end

endmodule

// File: rtl/rinv_blk_sel.sv
module rinv_blk_sel #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur_addr,
    input  logic [AW-1:0] remain,
    output logic [AW-1:0] blk
);
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] low_pow;
    logic [AW-1:0] top_pow;
    logic [AW-1:0] cand;

    // highest set bit of the remaining length, one leg per bit position
    for (genvar gi = 0; gi < AW; gi++) begin : g_msb
        if (gi == AW - 1) begin : g_top
            assign top_pow[gi] = remain[gi];
        end else begin : g_rest
            assign top_pow[gi] = remain[gi] & ~(|remain[AW-1:gi+1]);
        end
    end

    always_comb begin
        low_pow = cur_addr & (~cur_addr + ONE);
        cand    = (cur_addr == '0) ? remain : low_pow;
        blk     = (remain > cand) ? cand : top_pow;
    end

endmodule

// File: rtl/range_inv_seq.sv
module range_inv_seq
    import rinv_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINE_SHIFT = 4,
    parameter int INV_BIT    = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_start,
    input  logic [AW-1:0] req_end,
    input  logic          wb_mode,
    output logic          req_ready,
    input  logic          eng_busy,
    output logic          cmd_valid,
    output logic [AW-1:0] cmd_word,
    output logic [AW-1:0] cmd_mask,
    output logic          flush_req,
    output logic [AW-1:0] flush_start,
    output logic [AW-1:0] flush_end,
    output logic          done
);
    localparam logic [AW-1:0] ONE      = AW'(1);
    localparam logic [AW-1:0] INV_FLAG = ONE << INV_BIT;

    typedef struct packed {
        seq_state_e    state;
        logic [AW-1:0] addr;
        logic [AW-1:0] fin;
        logic [AW-1:0] remain;
        logic [AW-1:0] blk;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic          redirect;
    logic          empty;
    logic [AW-1:0] start_r;
    logic [AW-1:0] end_r;
    logic [AW-1:0] len;
    logic [AW-1:0] blk_sz;
    logic [AW-1:0] remain_cur;

    rinv_range_prep #(.AW(AW), .LINE_SHIFT(LINE_SHIFT)) i_prep (
        .raw_start (req_start),
        .raw_end   (req_end),
        .wb_mode   (wb_mode),
        .redirect  (redirect),
        .empty     (empty),
        .start_r   (start_r),
        .end_r     (end_r),
        .len       (len)
    );

    rinv_blk_sel #(.AW(AW)) i_blk (
        .cur_addr (r_q.addr),
        .remain   (r_q.remain),
        .blk      (blk_sz)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            S_IDLE: begin
                if (req_valid) begin
                    if (redirect) begin
                        r_d.state = S_HAND;
                        r_d.addr  = req_start;
                        r_d.fin   = req_end;
                    end else if (empty) begin
                        r_d.state = S_FIN;
                    end else begin
                        r_d.state  = S_PRE;
                        r_d.addr   = start_r;
                        r_d.fin    = end_r;
                        r_d.remain = len;
                    end
                end
            end
            S_PRE: begin
                if (!eng_busy) begin
                    r_d.state = S_ISSUE;
                end
            end
            S_ISSUE: begin
                r_d.blk   = blk_sz;
                r_d.state = S_WAIT;
            end
            S_WAIT: begin
                if (!eng_busy) begin
                    r_d.addr   = r_q.addr + r_q.blk;
                    r_d.remain = r_q.remain - r_q.blk;
                    r_d.state  = (r_q.remain == r_q.blk) ? S_FIN : S_ISSUE;
                end
            end
            S_FIN:   r_d.state = S_IDLE;
            S_HAND:  r_d.state = S_IDLE;
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: S_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign remain_cur  = r_q.remain;
    assign req_ready   = (r_q.state == S_IDLE);
    assign cmd_valid   = (r_q.state == S_ISSUE);
    assign cmd_word    = r_q.addr | INV_FLAG;
    assign cmd_mask    = ~(blk_sz - ONE);
    assign flush_req   = (r_q.state == S_HAND);
    assign flush_start = r_q.addr;
    assign flush_end   = r_q.fin;
    assign done        = (r_q.state == S_FIN);

endmodule

// File: rtl/range_inv_seq_chk.sv
module range_inv_seq_chk #(
    parameter int AW         = 32,
    parameter int LINE_SHIFT = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          eng_busy,
    input logic          cmd_valid,
    input logic [AW-1:0] cmd_word,
    input logic [AW-1:0] cmd_mask,
    input logic          flush_req,
    input logic          done,
    input logic [AW-1:0] blk,
    input logic [AW-1:0] remain
);
    localparam logic [AW-1:0] LOW = AW'((64'd1 << LINE_SHIFT) - 64'd1);

    // R5: a command only follows a cycle with the engine idle
    p_idle_before_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !$past(eng_busy));

    // R7: mask is a contiguous high mask of a block no smaller than a line
    p_mask_pow2_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($countones(~cmd_mask + AW'(1)) == 1) && ((cmd_mask & LOW) == '0));

    // R7: only the invalidate bit is set among the low control bits
    p_inv_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_word[0] && !cmd_word[1]));

    // R10: block base naturally aligned
    p_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (((cmd_word & ~cmd_mask) & ~LOW) == '0));

    // R8: block never exceeds what is left
    p_fits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (blk != '0) && (blk <= remain));

    // R11: single outstanding command
    p_single_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R3: hand-off is a lone pulse with no command or done
    p_hand_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> !flush_req);
    p_hand_alone_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> (!cmd_valid && !done && !req_ready));

    // R9: done is a single pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind range_inv_seq range_inv_seq_chk #(.AW(AW), .LINE_SHIFT(LINE_SHIFT)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .eng_busy  (eng_busy),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .cmd_mask  (cmd_mask),
    .flush_req (flush_req),
    .done      (done),
    .blk       (blk_sz),
    .remain    (remain_cur)
);

// File: tb/test_range_inv_seq.sv
`timescale 1ns/1ps
module test_range_inv_seq;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_start = '0;
    logic [AW-1:0] req_end = '0;
    logic          wb_mode = 1'b0;
    logic          req_ready;
    logic          eng_busy = 1'b0;
    logic          cmd_valid;
    logic [AW-1:0] cmd_word;
    logic [AW-1:0] cmd_mask;
    logic          flush_req;
    logic [AW-1:0] flush_start;
    logic [AW-1:0] flush_end;
    logic          done;

    range_inv_seq #(.AW(AW), .LINE_SHIFT(4), .INV_BIT(0)) i_range_inv_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_start(req_start),
        .req_end(req_end), .wb_mode(wb_mode), .req_ready(req_ready),
        .eng_busy(eng_busy), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .cmd_mask(cmd_mask), .flush_req(flush_req), .flush_start(flush_start),
        .flush_end(flush_end), .done(done)
    );

    always #10 clk = ~clk;   // 50 MHz

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    logic [31:0] exp_word [0:127];
    logic [31:0] exp_mask [0:127];
    logic [31:0] act_word [0:127];
    logic [31:0] act_mask [0:127];
    int          exp_n;
    int          act_n;
    bit          exp_flush;
    bit          got_flush;
    bit          got_done;
    logic [31:0] got_fs, got_fe;
    bit          hold_busy = 1'b0;
    int          busy_cnt = 0;

    // engine model and output monitor, on the falling edge
    always @(negedge clk) begin
        if (cmd_valid) begin
            if (act_n < 128) begin
                act_word[act_n] = cmd_word;
                act_mask[act_n] = cmd_mask;
            end
            act_n = act_n + 1;
            busy_cnt = 1 + int'($urandom % 3);
        end else if (busy_cnt > 0) begin
            busy_cnt = busy_cnt - 1;
        end
        eng_busy = hold_busy || (busy_cnt > 0);
        if (done) got_done = 1'b1;
        if (flush_req) begin
            got_flush = 1'b1;
            got_fs = flush_start;
            got_fe = flush_end;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // expected command list from the requirement text (R2, R3, R6, R7, R8)
    task automatic calc_expected(input logic [31:0] s, input logic [31:0] e, input bit wb);
        logic [31:0] rs, re, a, rem, cand, b, t;
        exp_n = 0;
        exp_flush = wb && ((s[3:0] != 0) || (e[3:0] != 0));
        if (!exp_flush) begin
            rs = s & ~32'hF;
            re = (e + 32'hF) & ~32'hF;
            if (re > rs) begin
                a = rs;
                rem = re - rs;
                while (rem != 0 && exp_n < 128) begin
                    if (a == 0) cand = rem;
                    else begin
                        cand = 32'h10;
                        while ((a & cand) == 0) cand = cand << 1;
                    end
                    if (rem > cand) b = cand;
                    else begin
                        t = 32'h8000_0000;
                        while ((t & rem) == 0) t = t >> 1;
                        b = t;
                    end
                    exp_word[exp_n] = a | 32'h1;
                    exp_mask[exp_n] = ~(b - 1);
                    exp_n++;
                    a = a + b;
                    rem = rem - b;
                end
            end
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #5;
    endtask

    task automatic run_case(input logic [31:0] s, input logic [31:0] e, input bit wb,
                            input bit pre_busy, input string tag);
        int k;
        calc_expected(s, e, wb);
        k = 0;
        while (!req_ready && k < 100) begin tick(); k++; end
        act_n = 0;
        got_flush = 1'b0;
        got_done = 1'b0;
        hold_busy = pre_busy;
        req_valid = 1'b1;
        req_start = s;
        req_end = e;
        wb_mode = wb;
        tick();
        req_valid = 1'b0;
        if (pre_busy) begin
            repeat (6) tick();
            check(act_n == 0, "R5", "command while busy", 32'(act_n), 32'd0);
            hold_busy = 1'b0;
        end
        k = 0;
        while (!(got_done || got_flush) && k < 3000) begin tick(); k++; end
        repeat (3) tick();
        check(got_flush == exp_flush, "R3", {tag, " hand-off"}, 32'(got_flush), 32'(exp_flush));
        if (exp_flush) begin
            check(got_fs == s, "R3", "flush_start", got_fs, s);
            check(got_fe == e, "R3", "flush_end", got_fe, e);
            check(act_n == 0, "R3", "commands on hand-off", 32'(act_n), 32'd0);
            check(!got_done, "R3", "done on hand-off", 32'(got_done), 32'd0);
        end else begin
            check(got_done, "R9", {tag, " done"}, 32'(got_done), 32'd1);
            check(act_n == exp_n, (exp_n == 0) ? "R9" : "R8", {tag, " command count"},
                  32'(act_n), 32'(exp_n));
            for (int i = 0; i < exp_n && i < act_n; i++) begin
                check(act_word[i] == exp_word[i], "R7", {tag, " cmd_word"}, act_word[i], exp_word[i]);
                check(act_mask[i] == exp_mask[i], "R6", {tag, " cmd_mask"}, act_mask[i], exp_mask[i]);
            end
        end
    endtask

    initial begin
        while (cycles < 190000) begin
            @(posedge clk);
            cycles++;
        end
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected finish", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] s, e, len, seed;
        bit wb;
        seed = $urandom(32'h5EED_0042);
        act_n = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: idle outputs after reset
        check(req_ready == 1'b1, "R1", "req_ready", 32'(req_ready), 32'd1);
        check(cmd_valid == 1'b0, "R1", "cmd_valid", 32'(cmd_valid), 32'd0);
        check(done == 1'b0, "R1", "done", 32'(done), 32'd0);
        check(flush_req == 1'b0, "R1", "flush_req", 32'(flush_req), 32'd0);

        run_case(32'h0000_1000, 32'h0000_2000, 1'b0, 1'b0, "R6 page");
        run_case(32'h0000_0000, 32'h0000_0030, 1'b0, 1'b0, "R6 zero base");
        run_case(32'h0000_1005, 32'h0000_1011, 1'b0, 1'b0, "R2 round");
        run_case(32'h0000_0005, 32'h0000_0005, 1'b0, 1'b0, "R2 sub-line");
        run_case(32'h0000_1005, 32'h0000_1020, 1'b1, 1'b0, "R3 start");
        run_case(32'h0000_1000, 32'h0000_1021, 1'b1, 1'b0, "R3 end");
        run_case(32'h0000_0ff0, 32'h0001_2340, 1'b1, 1'b0, "R4 aligned");
        run_case(32'h0000_0500, 32'h0000_0500, 1'b0, 1'b0, "R9 empty");
        run_case(32'h0000_0800, 32'h0000_0400, 1'b1, 1'b0, "R9 reversed");
        run_case(32'h0003_0010, 32'h0003_0400, 1'b0, 1'b1, "R5 pre-busy");
        run_case(32'h0000_0010, 32'h0100_0000, 1'b0, 1'b0, "R8 long");

        for (int n = 0; n < 200; n++) begin
            s = $urandom & 32'h7FFF_FFFF;
            if ($urandom % 2 == 0) s[3:0] = 4'h0;
            len = $urandom & ((32'd1 << ($urandom % 24)) - 1);
            e = (($urandom % 16) == 0) ? s - ($urandom % 64) : s + len;
            if ($urandom % 2 == 0) e[3:0] = 4'h0;
            wb = 1'($urandom % 2);
            run_case(s, e, wb, ($urandom % 8) == 0, "R6 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule